// File: doc/BRIEF.md
# Column-Bypassing Carry-Save Array Multiplier

This block multiplies two unsigned operands of equal width with no clock: a multiplicand `mcand` and a multiplier `mplier` go in, and their full-width product comes out. It is a carry-save grid of AND gates and full-adder cells. Each row of the grid is tied to one multiplier bit and each column to one multiplicand bit. Carries move from each row down into the row below it. A ripple-carry row at the bottom merges the remaining sums and carries into the upper half of the product.

Every adder cell is gated by the multiplicand bit of its column. When that bit is zero, the adder inputs are held at zero and a 2:1 multiplexer routes the incoming partial sum straight to the cell's sum output. The cell's carry output is held at zero at the same time. The whole column then stops toggling, which saves switching power when the multiplicand has zero bits. AND gates on the carry inputs of the bottom row keep the product exact whenever columns are bypassed.

Top module: `col_bypass_mult`

## Requirements
- R1: For every pair of operands, `product` equals `mcand * mplier` taken as unsigned numbers, at full width 2*WIDTH with no truncation.
- R2: When multiplicand bit j is 0, every adder cell in column j drives, as its sum output, the partial sum it receives from the row above, unchanged.
- R3: When multiplicand bit j is 0, every adder cell in column j drives a carry output of 0.
- R4: When either operand is all zeros, `product` is all zeros.
- R5: When `mcand` is all ones (no column is bypassed), `product` equals `mplier * (2^WIDTH - 1)`.
- R6: When `mcand` has exactly one bit set, at position j (every other column is bypassed), `product` equals `mplier` shifted left by j.
- R7: When both operands are all ones, `product` equals `(2^WIDTH - 1)^2`. For WIDTH = 4 this is 225 (0xE1).
- R8: The block is purely combinational: `product` follows an operand change with no clock edge in between. The low WIDTH product bits come from the column-0 cells of the rows, and the high WIDTH bits come from the bottom ripple row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | WIDTH | Unsigned multiplicand; bit j enables adder column j |
| mplier | input | WIDTH | Unsigned multiplier; bit i feeds row i of partial products |
| product | output | 2*WIDTH | Unsigned full-width product |

## Verification
The bench builds the block with its default WIDTH of 4. At that width all 256 operand pairs can be swept in well under a millisecond of simulated time. The sweep covers every combination of bypassed columns against every multiplier value, so each pattern of forced-zero carries reaches the bottom correction gates at least once. The targeted checks for the all-zero, all-one and one-hot operands are taken from the same sweep. They tie each corner case to its own requirement.

// File: rtl/col_bypass_mult.sv
module col_bypass_mult #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product
);
  localparam int N  = WIDTH;
  localparam int PW = 2 * WIDTH;

  logic [N-1:0] sum_q [N];
  logic [N-2:0] cry_q [N];
  logic [N-1:0] rc;

  for (genvar j = 0; j < N; j++) begin : g_row0
    assign sum_q[0][j] = mcand[j] & mplier[0];
  end
  assign cry_q[0] = '0;

  for (genvar i = 1; i < N; i++) begin : g_row
    assign sum_q[i][N-1] = mcand[N-1] & mplier[i];
    for (genvar j = 0; j < N - 1; j++) begin : g_cell
      logic en, pp, gs, gc, fs, fc;
      assign en = mcand[j];
      assign pp = en & mplier[i];
      assign gs = en & sum_q[i-1][j+1];
      assign gc = en & cry_q[i-1][j];
      assign fs = pp ^ gs ^ gc;
      assign fc = (pp & gs) | (pp & gc) | (gs & gc);
      assign sum_q[i][j] = en ? fs : sum_q[i-1][j+1];
      assign cry_q[i][j] = en ? fc : 1'b0;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_low
    assign product[i] = sum_q[i][0];
  end

  assign rc[0] = 1'b0;
  for (genvar j = 0; j < N - 1; j++) begin : g_merge
    logic mx, my;
    assign mx = sum_q[N-1][j+1];
    assign my = cry_q[N-1][j] & mcand[j];
    assign product[N+j] = mx ^ my ^ rc[j];
    assign rc[j+1] = (mx & my) | (mx & rc[j]) | (my & rc[j]);
  end
  assign product[PW-1] = rc[N-1];

  always_comb begin
    // R1
    product_exact_chk: assert (product == PW'(mcand) * PW'(mplier))
      else $error("product mismatch");
    // R4
    zero_operand_chk: assert (!((mcand == '0) || (mplier == '0)) || (product == '0))
      else $error("zero operand gave nonzero product");
    for (int i = 1; i < N; i++) begin
      for (int j = 0; j < N - 1; j++) begin
        // R2
        bypass_sum_chk: assert (mcand[j] || (sum_q[i][j] == sum_q[i-1][j+1]))
          else $error("bypassed cell altered partial sum");
        // R3
        bypass_carry_chk: assert (mcand[j] || !cry_q[i][j])
          else $error("bypassed cell raised carry");
      end
    end
  end
endmodule

// File: tb/tb_col_bypass_mult.sv
module tb_col_bypass_mult;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic [PW-1:0] product;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  col_bypass_mult #(.WIDTH(W)) dut (.mcand(mcand), .mplier(mplier), .product(product));

  task automatic chk(input string req, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d got=%0d exp=%0d", req, mcand, mplier, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(posedge clk);
    chk("R4 initial zero operands", product, '0);

    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        @(negedge clk);
        mcand  = W'(a);
        mplier = W'(b);
        @(posedge clk);
        chk("R1", product, PW'(a * b));
        if (a != (1 << W) - 1)
          chk("R2 R3 bypassed column", product, PW'(a * b));
        if (a == 0 || b == 0)
          chk("R4", product, '0);
        if (a == (1 << W) - 1)
          chk("R5", product, PW'(b * ((1 << W) - 1)));
        for (int j = 0; j < W; j++)
          if (a == (1 << j)) chk("R6", product, PW'(b) << j);
        if (a == (1 << W) - 1 && b == (1 << W) - 1)
          chk("R7", product, PW'(225));
      end
    end

    @(negedge clk);
    mcand  = 4'b1010;
    mplier = 4'b0111;
    #1;
    chk("R8 no clock edge", product, PW'(70));
    mcand = 4'b0101;
    #1;
    chk("R8 no clock edge", product, PW'(35));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule